// File: doc/BRIEF.md
# Fixed-Capacity Reshapeable Memory

This block is a single-port storage array of exactly 2048 bits. One parameter decides how those bits are viewed: 256 words of 8 bits, 512 of 4, 1024 of 2, or 2048 of 1. The ports are always sized for the widest case: an 11-bit address and 8-bit write and read data. Address bits above the selected depth and data bits above the selected width take no part in the access.

The address, write data and write enable can each be registered on the input clock, and the read data can be registered on a separate output clock. Every one of these registers is switched in or out by its own parameter, so the same array serves as a fully combinational lookup, as a pipelined RAM, or as anything in between. A write enable that is not registered opens a write pulse during the high phase of the input clock. A registered write enable commits the captured word on the next rising input edge. The contents start from a parameter image and the array has no reset, so with the write enable tied low the block acts as a ROM.

Top module: `ratio_ram`

## Requirements
- R1: Parameter RATIO selects the shape. 0 gives 256 x 8, 1 gives 512 x 4, 2 gives 1024 x 2 and 3 gives 2048 x 1. The word width is 8 >> RATIO and the depth is 256 << RATIO.
- R2: Only address bits [7+RATIO:0] are decoded. Any address with higher bits set reaches the same word as its low bits.
- R3: Read data bits at and above the word width always read 0. Write data bits at and above the word width are never stored.
- R4: Before any write, word i reads back as INIT_IMAGE[i*W +: W], where W is the word width.
- R5: With REG_WE = 0, a word is written while wr_en is high during the high phase of clk_in. After that phase the word holds the write data.
- R6: With REG_ADDR, REG_DIN and REG_WE all 1, the inputs are captured on a rising clk_in edge and the word is stored on the following rising edge. A new write can start on every cycle.
- R7: While the effective write enable is low, no stored word changes, whatever the address and write data do.
- R8: While the effective write enable is high, the read path presents the effective write data instead of the stored word.
- R9: With REG_DOUT = 1, rdata changes only on a rising clk_out edge, and then takes the value the read path had at that edge. With REG_DOUT = 0, rdata follows the effective address combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock: drives the input registers and the write pulse |
| clk_out | input | 1 | Output clock: drives the read data register |
| addr | input | 11 | Word address; only the low 8+RATIO bits are decoded |
| wdata | input | 8 | Write data; only the low 8>>RATIO bits are stored |
| wr_en | input | 1 | Write enable, active high |
| rdata | output | 8 | Read data, zero above the word width |

## Verification
A read and a write of the same word can fall in the same cycle, because the array has a single address. The bench provokes this by holding wr_en high while it sweeps every address, once in the combinational 512 x 4 shape and once in the fully registered 256 x 8 shape. In each cycle of the sweep it checks that rdata already shows the word being written, with its upper bits cleared. A later read-back sweep, made with wr_en low and the write data deliberately changed, then shows that the forwarded value actually reached the array and that nothing else was written.

// File: rtl/ratio_ram_pkg.sv
`timescale 1ns/1ps
package ratio_ram_pkg;
  localparam int TOTAL_BITS = 2048;
  localparam int MAX_AW     = 11;
  localparam int MAX_DW     = 8;
  localparam int BASE_AW    = 8;

  // word width for a given shape selector
  function automatic int shape_width(input int sel);
    return MAX_DW >> sel;
  endfunction

  // decoded address bits for a given shape selector
  function automatic int shape_abits(input int sel);
    return BASE_AW + sel;
  endfunction

  // number of words for a given shape selector
  function automatic int shape_depth(input int sel);
    return TOTAL_BITS / shape_width(sel);
  endfunction

  // first bit of a word inside the flat storage image
  function automatic int word_base(input int idx, input int width);
    return idx * width;
  endfunction
endpackage

// File: rtl/rr_pipe_stage.sv
`timescale 1ns/1ps
module rr_pipe_stage #(
  parameter int W          = 8,
  parameter bit REGISTERED = 1'b0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REGISTERED) begin : g_reg
      logic [W-1:0] held;
      always_ff @(posedge clk) held <= d;
      assign q = held;
    end else begin : g_thru
      logic unused_clk;
      assign unused_clk = clk;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/rr_store.sv
`timescale 1ns/1ps
module rr_store
  import ratio_ram_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter bit SYNC_WR = 1'b0,
  parameter logic [TOTAL_BITS-1:0] INIT_IMAGE = '0
) (
  input  logic          clk_in,
  input  logic [AW-1:0] addr_eff,
  input  logic [DW-1:0] din_eff,
  input  logic          we_eff,
  output logic [DW-1:0] rd_raw,
  output logic          wr_pulse
);
  localparam int DEPTH = 1 << AW;
  localparam int BITS  = DEPTH * DW;

  logic [BITS-1:0] store;

  initial store = INIT_IMAGE[BITS-1:0];

  function automatic logic [DW-1:0] word_at(input logic [BITS-1:0] img,
                                            input logic [AW-1:0] a);
    return img[word_base(int'(a), DW) +: DW];
  endfunction

  generate
    if (SYNC_WR) begin : g_sync
      // captured write commits on the next input clock edge
      assign wr_pulse = we_eff;
      always_ff @(posedge clk_in) begin
        if (wr_pulse) store[word_base(int'(addr_eff), DW) +: DW] <= din_eff;
      end
    end else begin : g_phase
      // write pulse open during the input clock high phase
      assign wr_pulse = we_eff & clk_in;
      always_latch begin
        if (wr_pulse) store[word_base(int'(addr_eff), DW) +: DW] <= din_eff;
      end
    end
  endgenerate

  // read path with forwarding of the word being written
  assign rd_raw = we_eff ? din_eff : word_at(store, addr_eff);

  logic armed = 1'b0;
  always_ff @(posedge clk_in) armed <= 1'b1;

  generate
    if (SYNC_WR) begin : g_chk_sync
      a_r6_write_lands: assert property (@(posedge clk_in) disable iff (!armed)
        we_eff |=> word_at(store, $past(addr_eff)) == $past(din_eff));
      a_r7_idle_keeps: assert property (@(posedge clk_in) disable iff (!armed)
        !we_eff |=> $stable(store));
    end else begin : g_chk_phase
      a_r5_phase_write: assert property (@(negedge clk_in) disable iff (!armed)
        we_eff |-> word_at(store, addr_eff) == din_eff);
    end
  endgenerate
endmodule

// File: rtl/ratio_ram.sv
`timescale 1ns/1ps
module ratio_ram
  import ratio_ram_pkg::*;
#(
  parameter int RATIO    = 0,
  parameter bit REG_ADDR = 1'b0,
  parameter bit REG_DIN  = 1'b0,
  parameter bit REG_WE   = 1'b0,
  parameter bit REG_DOUT = 1'b0,
  parameter logic [TOTAL_BITS-1:0] INIT_IMAGE = '0
) (
  input  logic              clk_in,
  input  logic              clk_out,
  input  logic [MAX_AW-1:0] addr,
  input  logic [MAX_DW-1:0] wdata,
  input  logic              wr_en,
  output logic [MAX_DW-1:0] rdata
);
  localparam int DW = shape_width(RATIO);
  localparam int AW = shape_abits(RATIO);

  logic [AW-1:0] addr_eff;
  logic [DW-1:0] din_eff;
  logic          we_eff;
  logic [DW-1:0] rd_raw;
  logic [DW-1:0] rd_q;
  logic          wr_pulse;

  rr_pipe_stage #(.W(AW), .REGISTERED(REG_ADDR)) u_addr_stage (
    .clk(clk_in), .d(addr[AW-1:0]), .q(addr_eff));
  rr_pipe_stage #(.W(DW), .REGISTERED(REG_DIN)) u_din_stage (
    .clk(clk_in), .d(wdata[DW-1:0]), .q(din_eff));
  rr_pipe_stage #(.W(1), .REGISTERED(REG_WE)) u_we_stage (
    .clk(clk_in), .d(wr_en), .q(we_eff));

  rr_store #(.DW(DW), .AW(AW), .SYNC_WR(REG_WE), .INIT_IMAGE(INIT_IMAGE)) u_store (
    .clk_in(clk_in), .addr_eff(addr_eff), .din_eff(din_eff), .we_eff(we_eff),
    .rd_raw(rd_raw), .wr_pulse(wr_pulse));

  rr_pipe_stage #(.W(DW), .REGISTERED(REG_DOUT)) u_dout_stage (
    .clk(clk_out), .d(rd_raw), .q(rd_q));

  assign rdata = MAX_DW'(rd_q);

  logic unused_pulse;
  assign unused_pulse = wr_pulse;

  generate
    if (AW < MAX_AW) begin : g_addr_spare
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[MAX_AW-1:AW];
    end
    if (DW < MAX_DW) begin : g_data_spare
      logic unused_data_hi;
      assign unused_data_hi = ^wdata[MAX_DW-1:DW];
    end
  endgenerate

  logic armed_o = 1'b0;
  always_ff @(posedge clk_out) armed_o <= 1'b1;

  generate
    if (REG_DOUT) begin : g_chk_out
      a_r9_out_follows: assert property (@(posedge clk_out) disable iff (!armed_o)
        armed_o |=> rdata == MAX_DW'($past(rd_raw)));
    end
  endgenerate
endmodule

// File: tb/tb_ratio_ram.sv
`timescale 1ns/1ps
module tb_ratio_ram;
  logic clk = 1'b0;
  logic clk_o = 1'b0;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #5 clk_o = ~clk_o;
  end

  function automatic logic [2047:0] make_image(input int dw, input int mul, input int add);
    logic [2047:0] img;
    img = '0;
    for (int i = 0; i < 2048 / dw; i++) begin
      int v;
      v = (i * mul + add) % (1 << dw);
      for (int b = 0; b < dw; b++) img[i * dw + b] = v[b];
    end
    return img;
  endfunction

  localparam logic [2047:0] IMG_U = make_image(4, 7, 3);
  localparam logic [2047:0] IMG_R = make_image(8, 13, 5);

  // expected words, restated arithmetically
  function automatic logic [7:0] init_u(input int i);  return 8'((i * 7 + 3) % 16);   endfunction
  function automatic logic [7:0] wr_u(input int i);    return 8'((i * 5 + 1) % 16);   endfunction
  function automatic logic [7:0] init_r(input int i);  return 8'((i * 13 + 5) % 256); endfunction
  function automatic logic [7:0] wr_r(input int i);    return 8'((i * 29 + 11) % 256); endfunction

  logic [10:0] u_addr = '0;
  logic [7:0]  u_din  = '0;
  logic        u_we   = 1'b0;
  logic [7:0]  u_rdata;

  logic [10:0] r_addr = '0;
  logic [7:0]  r_din  = '0;
  logic        r_we   = 1'b0;
  logic [7:0]  r_rdata;

  // 512 x 4, everything combinational
  ratio_ram #(.RATIO(1), .REG_ADDR(1'b0), .REG_DIN(1'b0), .REG_WE(1'b0), .REG_DOUT(1'b0),
              .INIT_IMAGE(IMG_U)) dut (
    .clk_in(clk), .clk_out(clk_o), .addr(u_addr), .wdata(u_din), .wr_en(u_we), .rdata(u_rdata));

  // 256 x 8, every register in
  ratio_ram #(.RATIO(0), .REG_ADDR(1'b1), .REG_DIN(1'b1), .REG_WE(1'b1), .REG_DOUT(1'b1),
              .INIT_IMAGE(IMG_R)) dut_r (
    .clk_in(clk), .clk_out(clk_o), .addr(r_addr), .wdata(r_din), .wr_en(r_we), .rdata(r_rdata));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // ---------- combinational 512 x 4 ----------
    // R4, R3: preloaded image visible, upper bits zero
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); #2;
      u_addr = 11'(i);
      #1 check("R4", u_rdata, init_u(i));
    end
    // R2: high address bits ignored
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); #2;
      u_addr = 11'(i) | 11'h200 | ((i % 2 == 1) ? 11'h400 : 11'h000);
      #1 check("R2", u_rdata, init_u(i));
    end
    // R8, R5, R7, R3: phase writes with forwarding
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); #2;
      u_addr = 11'(i);
      u_din  = 8'hF0 | wr_u(i);
      u_we   = 1'b1;
      #1 check("R8", u_rdata, wr_u(i));
      @(negedge clk); #2;
      u_we  = 1'b0;
      u_din = ~u_din;
      #1 check("R7", u_rdata, wr_u(i));
    end
    // R5: read back every word
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); #2;
      u_addr = 11'(i);
      #1 check("R5", u_rdata, wr_u(i));
    end

    // ---------- registered 256 x 8 ----------
    // R4 image through the pipeline, R9 hold until output edge
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk); #1;
      if (i > 0) check("R4", r_rdata, init_r(i - 1));
      #1;
      r_addr = 11'(i % 256);
      r_din  = 8'(i * 3);
      #1 if (i > 0) check("R9", r_rdata, init_r(i - 1));
    end
    // R6, R8: write every cycle, forwarded word seen one cycle later
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk); #1;
      if (i > 0) check("R8", r_rdata, wr_r(i - 1));
      #1;
      if (i < 256) begin
        r_addr = 11'(i);
        r_din  = wr_r(i);
        r_we   = 1'b1;
      end else begin
        r_we  = 1'b0;
        r_din = 8'h5A;
      end
    end
    repeat (2) @(negedge clk);
    // R6 read back, R7 with write data churning while disabled
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk); #1;
      if (i > 0) check("R6", r_rdata, wr_r(i - 1));
      #1;
      r_addr = 11'(i % 256);
      r_din  = ~wr_r(i % 256);
    end
    // R1: depth is 256 here, so bit 8 aliases onto the same word
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk); #1;
      if (i > 0) check("R1", r_rdata, wr_r(i - 1));
      #1;
      r_addr = 11'(i % 256) | 11'h100;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule